// File: doc/BRIEF.md
# Windowed Command and Status Register Unit

This unit is the host-facing control register of a network controller. One 16-bit location, at the same offset in every register window, serves two purposes. A host write to it is taken as a command: a 5-bit opcode in bits 15:11 and an 11-bit argument in bits 10:0. A host read from it returns the live status word. The unit keeps the current window number, which selects the register bank that the other offsets reach. It also keeps an indication-enable mask, an interrupt-enable mask and a set of latched events, and it drives an interrupt line.

Events arrive as one-cycle pulses from the datapath. Commands addressed to the MAC, DMA and media logic leave the unit as one-cycle strobes carrying the opcode and argument. Decoded stall, unstall and DMA-start pulses are also provided. Commands that take time (resets and stall/unstall) hold a command-busy flag for a fixed number of cycles. The host polls this flag before it issues the next command.

Top module: `csr_window_unit`

## Requirements
- R1: After reset the window is 0, the interrupt output is low, no strobe is active, and a status read returns 0 except for bit 11, which follows the DMA-busy input.
- R2: Opcode 1 sets the window to the low WIN_W argument bits. The status word stays readable at offset 0x0E whatever window is selected, and the window changes only through opcode 1 or opcode 0.
- R3: Each accepted command produces a one-cycle strobe in the cycle after the write. The strobe carries the written opcode and argument.
- R4: Opcode 6 with sub-code (argument bits 1:0) 0, 1, 2 or 3 pulses upload-stall, upload-unstall, download-stall or download-unstall. Opcode 20 with sub-code 0 or 1 pulses upload-start or download-start. At most one of these six pulses is active in any cycle.
- R5: Opcode 15 loads the indication mask from argument bits 10:1. A pulse on event input k sets status bit k+1 only if mask bit k+1 is set; otherwise the pulse has no effect.
- R6: Opcode 13 clears every pending status bit whose argument bit is 1. Argument bit 0 clears the interrupt latch. An event arriving in the same cycle as its acknowledge stays set.
- R7: Opcode 14 loads the interrupt mask from argument bits 10:1. Status bit 0 and the interrupt output rise one cycle after a pending bit meets a set interrupt-mask bit. They stay high until an acknowledge with bit 0 is accepted.
- R8: Opcodes 0, 5, 6 and 11 set status bit 12 for BUSY_CYC cycles. Command writes during that time are ignored.
- R9: Opcode 0 clears the window, both masks, all pending bits and the interrupt latch.
- R10: Status bit 11 mirrors the DMA-busy input. A read returns its data and valid flag one cycle after the read request. The data is the status word at offset 0x0E and 0 at any other offset.
- R11: Writes to any offset other than 0x0E do not act as commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Host write request |
| wr_addr_i | input | OFS_W | Host write offset |
| wr_data_i | input | 16 | Host write data (opcode 15:11, argument 10:0) |
| rd_en_i | input | 1 | Host read request |
| rd_addr_i | input | OFS_W | Host read offset |
| rd_valid_o | output | 1 | Read data valid, one cycle after request |
| rd_data_o | output | 16 | Read data |
| evt_i | input | NUM_EVT | Event pulses, input k maps to status bit k+1 |
| dma_busy_i | input | 1 | DMA engine busy level |
| window_o | output | WIN_W | Current register window |
| irq_o | output | 1 | Interrupt request |
| cmd_stb_o | output | 1 | Command strobe |
| cmd_op_o | output | 5 | Opcode of strobed command |
| cmd_arg_o | output | 11 | Argument of strobed command |
| up_stall_o | output | 1 | Upload stall pulse |
| up_unstall_o | output | 1 | Upload unstall pulse |
| dn_stall_o | output | 1 | Download stall pulse |
| dn_unstall_o | output | 1 | Download unstall pulse |
| up_start_o | output | 1 | Upload DMA start pulse |
| dn_start_o | output | 1 | Download DMA start pulse |

## Verification
The assertions assume that the event inputs and the DMA-busy level are synchronous to the clock. They also assume that reset is held for at least one edge before any host access. They do not assume that the host waits for the busy flag, so the property that writes are ignored while busy is exercised on purpose. The stimulus drives every input on the falling edge and issues one command write or read at a time through tasks. It deliberately issues a command during a busy window, an acknowledge that overlaps an event, and writes to offsets other than the command offset.

// File: rtl/csr_win_pkg.sv
`timescale 1ns/1ps
package csr_win_pkg;
  localparam int DATA_W = 16;
  localparam int OP_W   = 5;
  localparam int ARG_W  = 11;

  localparam logic [OP_W-1:0] OP_RESET  = 5'd0;
  localparam logic [OP_W-1:0] OP_WINSEL = 5'd1;
  localparam logic [OP_W-1:0] OP_RXRST  = 5'd5;
  localparam logic [OP_W-1:0] OP_STALL  = 5'd6;
  localparam logic [OP_W-1:0] OP_TXRST  = 5'd11;
  localparam logic [OP_W-1:0] OP_ACK    = 5'd13;
  localparam logic [OP_W-1:0] OP_INTEN  = 5'd14;
  localparam logic [OP_W-1:0] OP_INDEN  = 5'd15;
  localparam logic [OP_W-1:0] OP_DMAGO  = 5'd20;

  localparam int ST_LATCH   = 0;
  localparam int ST_DMABUSY = 11;
  localparam int ST_CMDBUSY = 12;

  localparam int DMA_PULSES = 6;

  typedef struct packed {
    logic [OP_W-1:0]  op;
    logic [ARG_W-1:0] arg;
  } cmd_word_t;

  function automatic logic op_is_long(input logic [OP_W-1:0] op);
    return (op == OP_RESET) || (op == OP_RXRST) ||
           (op == OP_STALL) || (op == OP_TXRST);
  endfunction
endpackage

// File: rtl/csr_cmd_decode.sv
`timescale 1ns/1ps
module csr_cmd_decode
  import csr_win_pkg::*;
#(
  parameter int BUSY_CYC = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cmd_wr,
  input  logic [DATA_W-1:0]     cmd_data,
  output logic                  accept,
  output cmd_word_t             cmd,
  output logic                  busy,
  output logic                  stb,
  output logic [OP_W-1:0]       stb_op,
  output logic [ARG_W-1:0]      stb_arg,
  output logic [DMA_PULSES-1:0] dma_pulse
);
  localparam int CNT_W = $clog2(BUSY_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYC);

  logic [CNT_W-1:0]      busy_cnt;
  logic [DMA_PULSES-1:0] dma_next;

  assign cmd    = cmd_word_t'(cmd_data);
  assign busy   = (busy_cnt != '0);
  assign accept = cmd_wr && !busy;

  always_comb begin
    dma_next = '0;
    if (cmd.op == OP_STALL) begin
      case (cmd.arg[1:0])
        2'd0:    dma_next[0] = 1'b1;
        2'd1:    dma_next[1] = 1'b1;
        2'd2:    dma_next[2] = 1'b1;
        default: dma_next[3] = 1'b1;
      endcase
    end else if (cmd.op == OP_DMAGO) begin
      if (cmd.arg[1:0] == 2'd0)      dma_next[4] = 1'b1;
      else if (cmd.arg[1:0] == 2'd1) dma_next[5] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_cnt  <= '0;
      stb       <= 1'b0;
      stb_op    <= '0;
      stb_arg   <= '0;
      dma_pulse <= '0;
    end else begin
      stb       <= accept;
      dma_pulse <= accept ? dma_next : '0;
      if (accept) begin
        stb_op  <= cmd.op;
        stb_arg <= cmd.arg;
      end
      if (accept && op_is_long(cmd.op)) busy_cnt <= CNT_LOAD;
      else if (busy)                    busy_cnt <= busy_cnt - 1'b1;
    end
  end

  assert_busy_blocks_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && cmd_wr) |=> !stb);
  assert_busy_load_R8: assert property (@(posedge clk) disable iff (rst)
    (accept && op_is_long(cmd.op)) |=> busy);
  assert_dma_onehot_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dma_pulse));
endmodule

// File: rtl/csr_event_bank.sv
`timescale 1ns/1ps
module csr_event_bank
  import csr_win_pkg::*;
#(
  parameter int NUM_EVT = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr_all,
  input  logic               ld_ind,
  input  logic               ld_int,
  input  logic               ack,
  input  logic [ARG_W-1:0]   arg,
  input  logic [NUM_EVT-1:0] evt,
  output logic [NUM_EVT-1:0] pend,
  output logic               latch
);
  logic [NUM_EVT-1:0] ind_en;
  logic [NUM_EVT-1:0] int_en;

  always_ff @(posedge clk) begin
    if (rst || clr_all) begin
      ind_en <= '0;
      int_en <= '0;
    end else begin
      if (ld_ind) ind_en <= arg[NUM_EVT:1];
      if (ld_int) int_en <= arg[NUM_EVT:1];
    end
  end

  for (genvar k = 0; k < NUM_EVT; k++) begin : g_evt
    always_ff @(posedge clk) begin
      if (rst || clr_all) pend[k] <= 1'b0;
      else pend[k] <= (pend[k] && !(ack && arg[k+1])) || (evt[k] && ind_en[k]);
    end

    assert_gate_R5: assert property (@(posedge clk) disable iff (rst)
      (!pend[k] && !(evt[k] && ind_en[k])) |=> !pend[k]);
    assert_ack_clear_R6: assert property (@(posedge clk) disable iff (rst)
      (ack && arg[k+1] && !evt[k]) |=> !pend[k]);
  end

  always_ff @(posedge clk) begin
    if (rst || clr_all)          latch <= 1'b0;
    else if (ack && arg[0])      latch <= 1'b0;
    else if (|(pend & int_en))   latch <= 1'b1;
  end

  assert_latch_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (latch && !(ack && arg[0]) && !clr_all) |=> latch);
endmodule

// File: rtl/csr_status_port.sv
`timescale 1ns/1ps
module csr_status_port
  import csr_win_pkg::*;
#(
  parameter int OFS_W   = 4,
  parameter int CMD_OFS = 14,
  parameter int NUM_EVT = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd_en,
  input  logic [OFS_W-1:0]   rd_addr,
  input  logic [NUM_EVT-1:0] pend,
  input  logic               latch,
  input  logic               dma_busy,
  input  logic               cmd_busy,
  output logic               rd_valid,
  output logic [DATA_W-1:0]  rd_data
);
  localparam logic [OFS_W-1:0] CMD_ADDR = OFS_W'(CMD_OFS);

  logic [DATA_W-1:0] status;

  always_comb begin
    status               = '0;
    status[ST_LATCH]     = latch;
    status[NUM_EVT:1]    = pend;
    status[ST_DMABUSY]   = dma_busy;
    status[ST_CMDBUSY]   = cmd_busy;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      rd_data  <= (rd_en && rd_addr == CMD_ADDR) ? status : '0;
    end
  end

  assert_rd_valid_R10: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
  assert_rd_offmiss_R10: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr != CMD_ADDR) |=> (rd_data == '0));
endmodule

// File: rtl/csr_window_unit.sv
`timescale 1ns/1ps
module csr_window_unit
  import csr_win_pkg::*;
#(
  parameter int OFS_W    = 4,
  parameter int CMD_OFS  = 14,
  parameter int WIN_W    = 3,
  parameter int NUM_EVT  = 10,
  parameter int BUSY_CYC = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en_i,
  input  logic [OFS_W-1:0]   wr_addr_i,
  input  logic [15:0]        wr_data_i,
  input  logic               rd_en_i,
  input  logic [OFS_W-1:0]   rd_addr_i,
  output logic               rd_valid_o,
  output logic [15:0]        rd_data_o,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               dma_busy_i,
  output logic [WIN_W-1:0]   window_o,
  output logic               irq_o,
  output logic               cmd_stb_o,
  output logic [4:0]         cmd_op_o,
  output logic [10:0]        cmd_arg_o,
  output logic               up_stall_o,
  output logic               up_unstall_o,
  output logic               dn_stall_o,
  output logic               dn_unstall_o,
  output logic               up_start_o,
  output logic               dn_start_o
);
  localparam logic [OFS_W-1:0] CMD_ADDR = OFS_W'(CMD_OFS);

  logic                  cmd_wr;
  logic                  accept;
  cmd_word_t             cmd;
  logic                  busy;
  logic [DMA_PULSES-1:0] dma_pulse;
  logic [NUM_EVT-1:0]    pend;
  logic                  latch;
  logic                  clr_all;

  assign cmd_wr  = wr_en_i && (wr_addr_i == CMD_ADDR);
  assign clr_all = accept && (cmd.op == OP_RESET);

  csr_cmd_decode #(.BUSY_CYC(BUSY_CYC)) u_dec (
    .clk       (clk),
    .rst       (rst),
    .cmd_wr    (cmd_wr),
    .cmd_data  (wr_data_i),
    .accept    (accept),
    .cmd       (cmd),
    .busy      (busy),
    .stb       (cmd_stb_o),
    .stb_op    (cmd_op_o),
    .stb_arg   (cmd_arg_o),
    .dma_pulse (dma_pulse)
  );

  csr_event_bank #(.NUM_EVT(NUM_EVT)) u_evt (
    .clk     (clk),
    .rst     (rst),
    .clr_all (clr_all),
    .ld_ind  (accept && cmd.op == OP_INDEN),
    .ld_int  (accept && cmd.op == OP_INTEN),
    .ack     (accept && cmd.op == OP_ACK),
    .arg     (cmd.arg),
    .evt     (evt_i),
    .pend    (pend),
    .latch   (latch)
  );

  csr_status_port #(.OFS_W(OFS_W), .CMD_OFS(CMD_OFS), .NUM_EVT(NUM_EVT)) u_stat (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en_i),
    .rd_addr  (rd_addr_i),
    .pend     (pend),
    .latch    (latch),
    .dma_busy (dma_busy_i),
    .cmd_busy (busy),
    .rd_valid (rd_valid_o),
    .rd_data  (rd_data_o)
  );

  always_ff @(posedge clk) begin
    if (rst || clr_all)                          window_o <= '0;
    else if (accept && cmd.op == OP_WINSEL)      window_o <= cmd.arg[WIN_W-1:0];
  end

  assign irq_o        = latch;
  assign up_stall_o   = dma_pulse[0];
  assign up_unstall_o = dma_pulse[1];
  assign dn_stall_o   = dma_pulse[2];
  assign dn_unstall_o = dma_pulse[3];
  assign up_start_o   = dma_pulse[4];
  assign dn_start_o   = dma_pulse[5];

  assert_window_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !(cmd_wr && (wr_data_i[15:11] == OP_WINSEL || wr_data_i[15:11] == OP_RESET))
      |=> $stable(window_o));
  assert_stb_source_R3: assert property (@(posedge clk) disable iff (rst)
    cmd_stb_o |-> $past(wr_en_i && wr_addr_i == CMD_ADDR));
  assert_offset_ignored_R11: assert property (@(posedge clk) disable iff (rst)
    !cmd_wr |=> !cmd_stb_o);
endmodule

// File: tb/tb_csr_window_unit.sv
`timescale 1ns/1ps
module tb_csr_window_unit;
  localparam int OFS_W = 4, WIN_W = 3, NEV = 10, BUSY = 4;
  localparam logic [3:0] CADDR = 4'hE;

  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 0, rd_en = 0, dma_busy = 0;
  logic [3:0] wr_addr = 0, rd_addr = 0;
  logic [15:0] wr_data = 0;
  logic [NEV-1:0] evt = 0;
  logic rd_valid, irq, stb, ups, upu, dns, dnu, upg, dng;
  logic [15:0] rd_data;
  logic [WIN_W-1:0] win;
  logic [4:0] op_o;
  logic [10:0] arg_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  csr_window_unit #(.OFS_W(OFS_W), .CMD_OFS(14), .WIN_W(WIN_W), .NUM_EVT(NEV), .BUSY_CYC(BUSY)) dut (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_valid_o(rd_valid), .rd_data_o(rd_data),
    .evt_i(evt), .dma_busy_i(dma_busy), .window_o(win), .irq_o(irq),
    .cmd_stb_o(stb), .cmd_op_o(op_o), .cmd_arg_o(arg_o),
    .up_stall_o(ups), .up_unstall_o(upu), .dn_stall_o(dns), .dn_unstall_o(dnu),
    .up_start_o(upg), .dn_start_o(dng));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [2:0] m_win; logic [9:0] m_ind, m_int, m_pend; logic m_latch;
  int m_cnt; logic m_stb; logic [4:0] m_op; logic [10:0] m_arg;
  logic [5:0] m_dma; logic m_rdv; logic [15:0] m_rdd;

  always @(posedge clk) begin
    if (rst) begin
      m_win = 0; m_ind = 0; m_int = 0; m_pend = 0; m_latch = 0; m_cnt = 0;
      m_stb = 0; m_op = 0; m_arg = 0; m_dma = 0; m_rdv = 0; m_rdd = 0;
    end else begin
      bit acc; logic [4:0] op; logic [10:0] arg;
      logic [9:0] np; logic nl;
      acc = wr_en && wr_addr == CADDR && m_cnt == 0;
      op = wr_data[15:11]; arg = wr_data[10:0];
      m_rdv = rd_en;
      m_rdd = (rd_en && rd_addr == CADDR) ? {3'b000, m_cnt != 0, dma_busy, m_pend, m_latch} : 16'h0;
      np = m_pend;
      if (acc && op == 13) np = np & ~arg[10:1];
      np = np | (evt & m_ind);
      nl = m_latch;
      if (acc && op == 13 && arg[0]) nl = 0;
      else if ((m_pend & m_int) != 0) nl = 1;
      m_pend = np; m_latch = nl;
      if (acc && op == 15) m_ind = arg[10:1];
      if (acc && op == 14) m_int = arg[10:1];
      if (acc && op == 1) m_win = arg[2:0];
      m_stb = acc;
      if (acc) begin m_op = op; m_arg = arg; end
      m_dma = 0;
      if (acc && op == 6) m_dma[arg[1:0]] = 1;
      if (acc && op == 20 && arg[1:0] < 2) m_dma[4 + arg[0]] = 1;
      if (m_cnt > 0) m_cnt--;
      if (acc && (op == 0 || op == 5 || op == 6 || op == 11)) m_cnt = BUSY;
      if (acc && op == 0) begin
        m_win = 0; m_ind = 0; m_int = 0; m_pend = 0; m_latch = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R2 window", 16'(win), 16'(m_win));
      chk("R7 irq", 16'(irq), 16'(m_latch));
      chk("R3 strobe", {stb, op_o, 10'h0}, {m_stb, m_op, 10'h0});
      chk("R3 arg", 16'(arg_o), 16'(m_arg));
      chk("R4 dma pulses", 16'({dng, upg, dnu, dns, upu, ups}), 16'(m_dma));
      chk("R10 rd_valid", 16'(rd_valid), 16'(m_rdv));
      chk("R10 rd_data", rd_data, m_rdd);
    end
  end

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask
  task automatic cmdw(input logic [4:0] op, input logic [10:0] arg);
    wr(CADDR, {op, arg});
  endtask
  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk); rd_en = 1; rd_addr = a;
    @(negedge clk); rd_en = 0; d = rd_data;
  endtask
  task automatic pulse(input logic [NEV-1:0] m);
    @(negedge clk); evt = m;
    @(negedge clk); evt = 0;
  endtask
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [15:0] s;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    rd(CADDR, s); chk("R1 status", s, 16'h0000);
    chk("R1 window", 16'(win), 0); chk("R1 irq", 16'(irq), 0);
    // R5/R7 event and interrupt
    cmdw(15, 11'h7FE); cmdw(14, 11'h010);
    pulse(10'h008); idle(2);
    rd(CADDR, s); chk("R5 event set", s, 16'h0011);
    chk("R7 irq high", 16'(irq), 1);
    // R5 masked event ignored
    cmdw(15, 11'h000); pulse(10'h001); idle(1);
    rd(CADDR, s); chk("R5 masked", s, 16'h0011);
    // R6 ack
    cmdw(13, 11'h010); idle(2);
    rd(CADDR, s); chk("R6 ack pending", s, 16'h0001);
    chk("R7 irq held", 16'(irq), 1);
    cmdw(13, 11'h001); idle(1);
    rd(CADDR, s); chk("R6 ack latch", s, 16'h0000);
    chk("R6 irq low", 16'(irq), 0);
    // R6 ack overlapping event
    cmdw(15, 11'h004);
    @(negedge clk); wr_en = 1; wr_addr = CADDR; wr_data = {5'd13, 11'h004}; evt = 10'h002;
    @(negedge clk); wr_en = 0; evt = 0;
    rd(CADDR, s); chk("R6 event wins", s, 16'h0004);
    cmdw(13, 11'h7FF);
    // R2 window
    cmdw(1, 11'h005); chk("R2 window set", 16'(win), 5);
    rd(CADDR, s); chk("R2 status in window", s, 16'h0000);
    // R11 other offset
    wr(4'h4, {5'd1, 11'h003});
    chk("R11 no strobe", 16'(stb), 0); chk("R11 window kept", 16'(win), 5);
    // R8 busy
    cmdw(6, 11'h000); chk("R4 up stall", 16'(ups), 1);
    rd(CADDR, s); chk("R8 busy bit", s, 16'h1000);
    cmdw(1, 11'h002); chk("R8 ignored", 16'(win), 5);
    chk("R8 no strobe", 16'(stb), 0);
    idle(6);
    rd(CADDR, s); chk("R8 busy cleared", s, 16'h0000);
    // R9 reset command
    cmdw(15, 11'h7FE); cmdw(14, 11'h7FE); cmdw(1, 11'h006);
    pulse(10'h3FF); idle(2);
    chk("R9 irq before", 16'(irq), 1);
    cmdw(0, 11'h000); idle(6);
    rd(CADDR, s); chk("R9 status cleared", s, 16'h0000);
    chk("R9 window", 16'(win), 0); chk("R9 irq", 16'(irq), 0);
    pulse(10'h3FF); idle(1);
    rd(CADDR, s); chk("R9 masks cleared", s, 16'h0000);
    // R10
    dma_busy = 1;
    rd(CADDR, s); chk("R10 dma bit", s, 16'h0800);
    rd(4'h3, s); chk("R10 other offset", s, 16'h0000);
    dma_busy = 0;
    // R3/R4 strobes
    cmdw(20, 11'h001); chk("R4 dn start", 16'(dng), 1);
    chk("R3 op", 16'(op_o), 20); chk("R3 arg", 16'(arg_o), 1);
    cmdw(20, 11'h000); chk("R4 up start", 16'(upg), 1);
    cmdw(6, 11'h003); chk("R4 dn unstall", 16'(dnu), 1);
    idle(6);
    cmdw(6, 11'h002); chk("R4 dn stall", 16'(dns), 1);
    idle(6);
    cmdw(6, 11'h001); chk("R4 up unstall", 16'(upu), 1);
    idle(6);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule